// File: doc/BRIEF.md
# Local Bus Burst Master Sequencer

This block is the local-bus master of a bridge. An internal source hands it one request at a time: a start address, a direction, a count of 32-bit lwords and a burst-enable flag. The block then runs the address cycles and data phases on a non-multiplexed local bus. It drives an active-low address strobe, an address latch enable, an active-low burst-last indication, the lword address and the direction. It stretches each data phase by a programmable wait-state count. It also obeys a ready input and a burst-terminate input from the slave.

A configuration bit, captured with each request, selects how long a burst may run. In limited mode, bursts are cut into accesses of at most four lwords, and each access gets its own address cycle. In continuous mode, one access carries the whole count unless the slave asserts burst-terminate. That input ends the current data phase and forces a fresh address cycle at the next lword address, after which the remaining transfers go on. Toward the internal side the block gives a request acknowledge, a per-lword `beat_valid` pulse and a `done` pulse.

Top module: `lbm_burst_seq`

## Requirements
- R1: During and straight after reset, `lb_ads_n` and `lb_blast_n` are 1, `lb_ale`, `beat_valid`, `done` and `req_ack` are 0.
- R2: Each access begins with exactly one address clock in which `lb_ads_n` is 0 and `lb_ale` is 1 and `lb_addr` holds the access's first lword address; in every data clock that follows, `lb_ale` is 0 and `lb_ads_n` is 1.
- R3: With `lb_ready_n` held at 1, every data phase lasts `cfg_wait`+1 clocks (4-bit count); with `lb_ready_n` at 0 a data phase ends in its first clock. `beat_valid` is 1 in the last clock of each data phase.
- R4: Consecutive lwords of a request use addresses that rise by 4 bytes; `lb_addr` during a data phase is the address of that lword.
- R5: `lb_blast_n` is 0 during the final data phase of an access and 1 in every other clock.
- R6: With `cfg_cont`=0 and `req_burst`=1, a request of more than four lwords is split into accesses of four lwords each (the last one may be shorter), each opened by its own address clock.
- R7: With `cfg_cont`=1 and `req_burst`=1 and no burst-terminate, the whole request is one access with a single address clock.
- R8: `lb_bterm_n`=0 during a data phase ends that phase in its clock, and if it was not the last transfer of the access, the next clock is a new address clock at the next lword address; the new access is sized from the remaining count with the same mode rules.
- R9: Burst-terminate on the final transfer of an access ends the access normally with no extra address clock.
- R10: With `req_burst`=0, every lword is its own one-lword access with its own address clock and `lb_blast_n` low in its data phase.
- R11: `req_ack` is 1 only while the block is idle and `req_valid` is 1; `done` is a one-clock pulse in the clock after the last `beat_valid` of a request; `lb_wr` equals the captured `req_write` in every address clock.
- R12: A `req_count` of 0 is treated as a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Internal request present |
| req_ack | output | 1 | Request accepted this clock |
| req_addr | input | AW | Byte address of the first lword |
| req_write | input | 1 | 1 for write, 0 for read |
| req_count | input | CW | Number of lwords (0 means 1) |
| req_burst | input | 1 | 1 allows bursting, 0 forces single-lword accesses |
| cfg_cont | input | 1 | 1 selects continuous burst, 0 limited burst |
| cfg_wait | input | WSW | Wait states per data phase |
| lb_addr | output | AW | Local address of the current lword |
| lb_wr | output | 1 | Direction of the current request |
| lb_ads_n | output | 1 | Address strobe, low in the address clock |
| lb_ale | output | 1 | Address latch enable, high in the address clock |
| lb_blast_n | output | 1 | Burst-last, low in the final data phase of an access |
| lb_ready_n | input | 1 | Slave ready, low ends a data phase |
| lb_bterm_n | input | 1 | Burst terminate, low ends the phase and the access |
| beat_valid | output | 1 | One lword transferred this clock |
| done | output | 1 | Request finished |

## Verification
The bench aims at the clocks where access boundaries fall. In limited mode it crosses the four-lword edge, and a design that miscounted would run a fifth beat or drop an address clock. It raises burst-terminate in the middle of a burst, where a faulty design either keeps bursting or restarts at the wrong address. It also raises burst-terminate on the final transfer, where an eager design would open a spurious extra access. Wait-state gaps are measured between events, so an off-by-one phase length shows up directly. A zero count and single-lword mode are also checked: a design that got them wrong would transfer a wrapped count or burst.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

  typedef enum logic [1:0] {
    LBM_IDLE = 2'd0,
    LBM_ADDR = 2'd1,
    LBM_DATA = 2'd2
  } lbm_state_e;

  // A zero request is serviced as a single lword.
  function automatic int unsigned lbm_clamp_count(input int unsigned cnt);
    return (cnt == 0) ? 1 : cnt;
  endfunction

  // Length of the access opened now, given the lwords still owed.
  function automatic int unsigned lbm_access_len(input int unsigned remaining,
                                                 input logic burst_en,
                                                 input logic cont_en,
                                                 input int unsigned limit);
    if (!burst_en) return 1;
    if (cont_en) return remaining;
    return (remaining < limit) ? remaining : limit;
  endfunction

endpackage

// File: rtl/lbm_phase_timer.sv
module lbm_phase_timer #(
  parameter int WSW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [WSW-1:0] wait_in,
  input  logic           in_data,
  input  logic           ready_n,
  input  logic           bterm_n,
  output logic           phase_end,
  output logic           bterm_hit
);

  logic [WSW-1:0] ws_q;
  logic [WSW-1:0] cnt_q;
  logic           wait_over;

  assign wait_over = (cnt_q == ws_q);
  assign bterm_hit = in_data && !bterm_n;
  assign phase_end = in_data && (!ready_n || !bterm_n || wait_over);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q <= '0;
    end else if (load) begin
      ws_q <= wait_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!in_data || phase_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> (cnt_q <= ws_q));

  // R3
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && phase_end) |=> (cnt_q == '0));

endmodule

// File: rtl/lbm_beat_track.sv
module lbm_beat_track #(
  parameter int AW    = 32,
  parameter int CW    = 8,
  parameter int LIMIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_count,
  input  logic          req_burst,
  input  logic          req_write,
  input  logic          cfg_cont,
  input  logic          open_access,
  input  logic          beat,
  output logic [AW-1:0] cur_addr,
  output logic          cur_wr,
  output logic          last_total,
  output logic          last_access
);
  import lbm_pkg::*;

  localparam int LWORD_BYTES = 4;
  localparam logic [AW-1:0] ADDR_STEP = AW'(LWORD_BYTES);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] total_q;
  logic [CW-1:0] acc_q;
  logic          burst_q;
  logic          cont_q;
  logic          wr_q;
  logic [CW-1:0] open_len;
  logic [CW-1:0] load_total;

  assign open_len   = CW'(lbm_access_len(int'(total_q), burst_q, cont_q, LIMIT));
  assign load_total = CW'(lbm_clamp_count(int'(req_count)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      total_q <= '0;
      acc_q   <= '0;
      burst_q <= 1'b0;
      cont_q  <= 1'b0;
      wr_q    <= 1'b0;
    end else if (load) begin
      addr_q  <= req_addr;
      total_q <= load_total;
      acc_q   <= '0;
      burst_q <= req_burst;
      cont_q  <= cfg_cont;
      wr_q    <= req_write;
    end else if (open_access) begin
      acc_q <= open_len;
    end else if (beat) begin
      addr_q  <= addr_q + ADDR_STEP;
      total_q <= total_q - 1'b1;
      acc_q   <= acc_q - 1'b1;
    end
  end

  assign cur_addr    = addr_q;
  assign cur_wr      = wr_q;
  assign last_total  = (total_q == CW'(1));
  assign last_access = (acc_q == CW'(1));

  // R6
  limited_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_q && burst_q) |-> (acc_q <= CW'(LIMIT)));

  // R10
  single_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_q |-> (acc_q <= CW'(1)));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !load && !open_access) |=> (cur_addr - $past(cur_addr) == ADDR_STEP));

endmodule

// File: rtl/lbm_ctrl_fsm.sv
module lbm_ctrl_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic phase_end,
  input  logic bterm_hit,
  input  logic last_total,
  input  logic last_access,
  output logic load,
  output logic open_access,
  output logic in_data,
  output logic ads_n,
  output logic ale,
  output logic blast_n,
  output logic done
);
  import lbm_pkg::*;

  lbm_state_e state_q, state_d;
  logic       done_q;
  logic       reopen;

  assign load        = (state_q == LBM_IDLE) && req_valid;
  assign open_access = (state_q == LBM_ADDR);
  assign in_data     = (state_q == LBM_DATA);
  assign reopen      = last_access || bterm_hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LBM_IDLE: if (req_valid) state_d = LBM_ADDR;
      LBM_ADDR: state_d = LBM_DATA;
      LBM_DATA: begin
        if (phase_end) begin
          if (last_total)  state_d = LBM_IDLE;
          else if (reopen) state_d = LBM_ADDR;
          else             state_d = LBM_DATA;
        end
      end
      default: state_d = LBM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LBM_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= in_data && phase_end && last_total;
    end
  end

  assign ads_n   = !open_access;
  assign ale     = open_access;
  assign blast_n = !(in_data && last_access);
  assign done    = done_q;

  // R2
  ads_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |=> ads_n);

  // R2
  ale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && in_data));

  // R5
  blast_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blast_n |-> (!ale && ads_n));

  // R8
  bterm_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end && bterm_hit && !last_total) |=> !ads_n);

  // R9
  bterm_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end && bterm_hit && last_total) |=> (ads_n && done));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (ads_n && !in_data));

endmodule

// File: rtl/lbm_burst_seq.sv
module lbm_burst_seq #(
  parameter int AW    = 32,
  parameter int CW    = 8,
  parameter int WSW   = 4,
  parameter int LIMIT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ack,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_write,
  input  logic [CW-1:0]  req_count,
  input  logic           req_burst,
  input  logic           cfg_cont,
  input  logic [WSW-1:0] cfg_wait,
  output logic [AW-1:0]  lb_addr,
  output logic           lb_wr,
  output logic           lb_ads_n,
  output logic           lb_ale,
  output logic           lb_blast_n,
  input  logic           lb_ready_n,
  input  logic           lb_bterm_n,
  output logic           beat_valid,
  output logic           done
);

  logic load;
  logic open_access;
  logic in_data;
  logic phase_end;
  logic bterm_hit;
  logic last_total;
  logic last_access;

  lbm_ctrl_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .phase_end   (phase_end),
    .bterm_hit   (bterm_hit),
    .last_total  (last_total),
    .last_access (last_access),
    .load        (load),
    .open_access (open_access),
    .in_data     (in_data),
    .ads_n       (lb_ads_n),
    .ale         (lb_ale),
    .blast_n     (lb_blast_n),
    .done        (done)
  );

  lbm_phase_timer #(.WSW(WSW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .wait_in   (cfg_wait),
    .in_data   (in_data),
    .ready_n   (lb_ready_n),
    .bterm_n   (lb_bterm_n),
    .phase_end (phase_end),
    .bterm_hit (bterm_hit)
  );

  lbm_beat_track #(.AW(AW), .CW(CW), .LIMIT(LIMIT)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .req_addr    (req_addr),
    .req_count   (req_count),
    .req_burst   (req_burst),
    .req_write   (req_write),
    .cfg_cont    (cfg_cont),
    .open_access (open_access),
    .beat        (phase_end),
    .cur_addr    (lb_addr),
    .cur_wr      (lb_wr),
    .last_total  (last_total),
    .last_access (last_access)
  );

  assign req_ack    = load;
  assign beat_valid = phase_end;

  // R3
  beat_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (lb_ads_n && !lb_ale));

  // R11
  done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(beat_valid));

endmodule

// File: tb/lbm_burst_seq_tb.sv
module lbm_burst_seq_tb;

  localparam int EV_A = 0;
  localparam int EV_B = 1;
  localparam int EV_D = 2;

  typedef struct {
    int          kind;
    logic [31:0] addr;
    bit          last;
    bit          wr;
    int          gap;
    string       tag;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ack;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_count = '0;
  logic        req_burst = 1'b0;
  logic        cfg_cont = 1'b0;
  logic [3:0]  cfg_wait = '0;
  logic [31:0] lb_addr;
  logic        lb_wr;
  logic        lb_ads_n;
  logic        lb_ale;
  logic        lb_blast_n;
  logic        lb_ready_n = 1'b1;
  logic        lb_bterm_n;
  logic        beat_valid;
  logic        done;

  int  checks = 0;
  int  errors = 0;
  int  cyc = 0;
  int  last_ev_cyc = 0;
  int  bt_cnt = 0;
  int  bt_target = 0;
  bit  bt_en = 1'b0;
  bit  finished = 1'b0;
  ev_t exp_q[$];

  always #2 clk = ~clk;

  // Terminate is raised in the data clocks of the chosen lword only.
  assign lb_bterm_n = !(bt_en && (bt_cnt == bt_target) && lb_ads_n);

  lbm_burst_seq u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ack    (req_ack),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_count  (req_count),
    .req_burst  (req_burst),
    .cfg_cont   (cfg_cont),
    .cfg_wait   (cfg_wait),
    .lb_addr    (lb_addr),
    .lb_wr      (lb_wr),
    .lb_ads_n   (lb_ads_n),
    .lb_ale     (lb_ale),
    .lb_blast_n (lb_blast_n),
    .lb_ready_n (lb_ready_n),
    .lb_bterm_n (lb_bterm_n),
    .beat_valid (beat_valid),
    .done       (done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic [31:0] addr, input bit last,
                      input bit wr, input int gap, input string tag);
    ev_t e;
    e.kind = kind; e.addr = addr; e.last = last; e.wr = wr; e.gap = gap; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Reference model: expected address clocks, beats and done.
  task automatic build(input logic [31:0] addr, input int cnt, input bit wr,
                       input bit burst, input bit cont, input int ws,
                       input bit rdy_lo, input int bt_beat, input string tag);
    int eff = (cnt == 0) ? 1 : cnt;
    int dg  = rdy_lo ? 1 : ws + 1;
    int idx = 0;
    bit first = 1'b1;
    while (idx < eff) begin
      int rem = eff - idx;
      int len;
      push(EV_A, addr + 32'(4 * idx), 1'b0, wr, first ? 0 : 1, tag);
      first = 1'b0;
      len = !burst ? 1 : (cont ? rem : ((rem < 4) ? rem : 4));
      for (int j = 0; j < len; j++) begin
        bit lj = (j == len - 1);
        bit bt = (idx == bt_beat);
        push(EV_B, addr + 32'(4 * idx), lj, wr, bt ? 1 : dg, tag);
        idx++;
        if (bt && !lj) break;
      end
    end
    push(EV_D, '0, 1'b0, wr, 1, tag);
  endtask

  task automatic observe(input int kind);
    ev_t e;
    int  gap = cyc - last_ev_cyc;
    last_ev_cyc = cyc;
    if (exp_q.size() == 0) begin
      check(1'b0, "R2", "unexpected event kind", kind, -1);
      return;
    end
    e = exp_q.pop_front();
    check(kind == e.kind, e.tag, "event kind", kind, e.kind);
    if (kind != e.kind) return;
    if (e.gap != 0) check(gap == e.gap, e.tag, "cycles since previous event (R3)", gap, e.gap);
    if (kind == EV_A) begin
      check(lb_addr == e.addr, e.tag, "address clock addr (R2)", lb_addr, e.addr);
      check(lb_ale == 1'b1, e.tag, "ale in address clock (R2)", lb_ale, 1);
      check(lb_wr == e.wr, e.tag, "direction (R11)", lb_wr, e.wr);
    end else if (kind == EV_B) begin
      check(lb_addr == e.addr, e.tag, "beat addr (R4)", lb_addr, e.addr);
      check(lb_ale == 1'b0, e.tag, "ale in data (R2)", lb_ale, 0);
      check((!lb_blast_n) == e.last, e.tag, "burst-last (R5)", !lb_blast_n, e.last);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!lb_ads_n) observe(EV_A);
      if (beat_valid) observe(EV_B);
      if (done) observe(EV_D);
    end
  end

  always @(posedge clk) begin
    if (rst_n && beat_valid) bt_cnt <= bt_cnt + 1;
  end

  task automatic run_req(input logic [31:0] addr, input int cnt, input bit wr,
                         input bit burst, input bit cont, input int ws,
                         input bit rdy_lo, input int bt_beat, input string tag);
    @(negedge clk);
    req_addr   = addr;
    req_count  = 8'(cnt);
    req_write  = wr;
    req_burst  = burst;
    cfg_cont   = cont;
    cfg_wait   = 4'(ws);
    lb_ready_n = !rdy_lo;
    bt_target  = bt_cnt + bt_beat;
    bt_en      = (bt_beat >= 0);
    build(addr, cnt, wr, burst, cont, ws, rdy_lo, bt_beat, tag);
    req_valid = 1'b1;
    #1;
    check(req_ack == 1'b1, "R11", "ack while idle", req_ack, 1);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1;
    #1;
    check(req_ack == 1'b0, "R11", "ack while busy", req_ack, 0);
    req_valid = 1'b0;
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    bt_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(lb_ads_n == 1'b1, "R1", "ads_n in reset", lb_ads_n, 1);
    check(lb_ale == 1'b0, "R1", "ale in reset", lb_ale, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(lb_blast_n == 1'b1, "R1", "blast_n after reset", lb_blast_n, 1);
    check(beat_valid == 1'b0, "R1", "beat_valid after reset", beat_valid, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(req_ack == 1'b0, "R1", "ack after reset", req_ack, 0);

    // R7: continuous, one access, zero-wait ready
    run_req(32'h0000_1000, 6, 1'b1, 1'b1, 1'b1, 5, 1'b1, -1, "R7");
    // R6: limited split 4+4+2 with 2 wait states
    run_req(32'h0000_2000, 10, 1'b0, 1'b1, 1'b0, 2, 1'b0, -1, "R6");
    // R3: long wait states, ready never asserted
    run_req(32'h0000_2F00, 2, 1'b0, 1'b1, 1'b1, 15, 1'b0, -1, "R3");
    // R10: single-lword accesses
    run_req(32'h0000_3000, 3, 1'b1, 1'b0, 1'b1, 1, 1'b0, -1, "R10");
    // R8: terminate mid-burst in continuous mode
    run_req(32'h0000_4000, 6, 1'b0, 1'b1, 1'b1, 1, 1'b0, 2, "R8");
    // R8: terminate mid-burst in limited mode
    run_req(32'h0000_5000, 6, 1'b1, 1'b1, 1'b0, 0, 1'b1, 1, "R8");
    // R9: terminate on the final transfer
    run_req(32'h0000_6000, 4, 1'b0, 1'b1, 1'b1, 3, 1'b0, 3, "R9");
    // R12: zero count behaves as one lword
    run_req(32'h0000_7000, 0, 1'b1, 1'b1, 1'b1, 0, 1'b1, -1, "R12");
    // R4/R5: limited boundary exactly at four lwords
    run_req(32'h0000_8FF8, 4, 1'b1, 1'b1, 1'b0, 0, 1'b1, -1, "R5");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, %0d events pending actual=0 expected=1", exp_q.size());
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule